// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block is the clocked timing core of a supply supervisor. It combines two reset causes: a synchronous supply-good flag, which stands in for an external voltage comparator, and an asynchronous active-low push-button input. It drives a system reset in both polarities. While either cause is active, reset is held. Once the last cause clears, reset is released only after a stretch of `TIMEOUT_CYCLES` clock ticks, so every reset pulse is at least that long however brief its cause was.

The release timer is held at zero while any cause is present, and it starts again from zero whenever a cause returns. A brief supply dip or button press during the countdown therefore extends the reset seamlessly. Neither output glitches. The timeout is a parameter in clock cycles. Silicon uses the real value of roughly 200 ms, which is 2,000,000 cycles at 10 MHz. Simulation scales it down.

Top module: `sup_reset_gen`

## Requirements
- R1: When `supply_ok_i` is sampled low at a clock edge, both outputs show reset asserted (`rst_o`=1, `rst_n_o`=0) after that same edge.
- R2: A low on `man_rst_n_i` passes through a `SYNC_STAGES`-flop synchroniser. Reset is asserted after the edge that follows its arrival at the synchroniser output, which is `SYNC_STAGES`+1 edges after the input is first sampled low.
- R3: Once `supply_ok_i` goes high and no manual cause is present, reset releases exactly `TIMEOUT_CYCLES` clock edges after the last edge at which a cause was sampled.
- R4: After `man_rst_n_i` returns high, reset releases `TIMEOUT_CYCLES` + `SYNC_STAGES` edges later.
- R5: A cause lasting a single clock cycle still produces a reset pulse of the full `TIMEOUT_CYCLES` length.
- R6: A new cause that arrives during the countdown restarts the timer from zero. Reset stays asserted continuously, without a one-cycle release.
- R7: `rst_n_o` is always the complement of `rst_o`.
- R8: While the synchronous power-on reset `rst` is high, both outputs are asserted and the timer is cleared. If the supply is still bad when `rst` drops, reset stays asserted until the supply becomes good and the full timeout has elapsed.
- R9: Once released, reset stays deasserted for as long as no cause is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_ok_i | input | 1 | Synchronous flag, 1 when supply is above threshold |
| man_rst_n_i | input | 1 | Asynchronous active-low manual reset request |
| rst_n_o | output | 1 | Active-low system reset, registered |
| rst_o | output | 1 | Active-high system reset, registered |

## Verification
The hardest situation to reach is a cause that arrives partway through a countdown. From the ports, only the visible reset level shows whether the timer truly restarted or simply kept running. The bench lets the countdown run partway, injects a one-cycle supply dip or a one-cycle button press, and then samples the outputs on every cycle. This checks that reset never dropped. It also counts the exact number of cycles to release measured from the new cause, so a timer that was not reloaded would release too early and be caught.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef struct packed {
    logic act_hi;
    logic act_lo;
  } rst_pair_t;

  function automatic rst_pair_t drive_pair(input logic held);
    rst_pair_t p;
    p.act_hi = held;
    p.act_lo = ~held;
    return p;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RESET_VAL;
        else     chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 2000000
) (
  input  logic clk,
  input  logic rst,
  input  logic cause_i,
  output logic held_d_o
);

  localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          held_q, held_d;

  always_comb begin
    cnt_d  = cnt_q;
    held_d = held_q;
    if (cause_i) begin
      cnt_d  = '0;
      held_d = 1'b1;
    end else if (held_q) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        held_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      held_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      held_q <= held_d;
    end
  end

  assign held_d_o = held_d;

endmodule

// File: rtl/sup_out_stage.sv
module sup_out_stage
  import sup_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic held_i,
  output logic rst_o,
  output logic rst_n_o
);

  rst_pair_t pair_q;

  always_ff @(posedge clk) begin
    if (rst) pair_q <= drive_pair(1'b1);
    else     pair_q <= drive_pair(held_i);
  end

  assign rst_o   = pair_q.act_hi;
  assign rst_n_o = pair_q.act_lo;

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int unsigned TIMEOUT_CYCLES = 2000000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic man_rst_n_i,
  output logic rst_n_o,
  output logic rst_o
);

  logic mr_n_sync;
  logic cause;
  logic held_d;

  sup_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_mr_sync (
    .clk(clk),
    .rst(rst),
    .d_i(man_rst_n_i),
    .q_o(mr_n_sync)
  );

  assign cause = ~supply_ok_i | ~mr_n_sync;

  sup_hold_timer #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .cause_i (cause),
    .held_d_o(held_d)
  );

  sup_out_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .held_i (held_d),
    .rst_o  (rst_o),
    .rst_n_o(rst_n_o)
  );

endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
  parameter int unsigned TIMEOUT_CYCLES = 2000000
) (
  input logic clk,
  input logic rst,
  input logic supply_ok_i,
  input logic mr_n_sync,
  input logic rst_o,
  input logic rst_n_o
);

  localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 2) + 1;
  localparam logic [CW-1:0] SAT = CW'(TIMEOUT_CYCLES + 1);

  logic [CW-1:0] calm_q;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok_i || !mr_n_sync) calm_q <= '0;
    else if (calm_q != SAT)                calm_q <= calm_q + 1'b1;
  end

  assert_supply_bad_R1: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> rst_o);

  assert_manual_R2: assert property (@(posedge clk) disable iff (rst)
    !mr_n_sync |=> rst_o);

  // R3 / R4 / R5 / R6: release only after exactly the full quiet window
  assert_full_width_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_o) |-> calm_q == CW'(TIMEOUT_CYCLES));

  assert_polarity_R7: assert property (@(posedge clk) disable iff (rst)
    rst_n_o == !rst_o);

  assert_por_R8: assert property (@(posedge clk)
    rst |=> rst_o && !rst_n_o);

  assert_stay_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !rst_o && supply_ok_i && mr_n_sync |=> !rst_o);

endmodule

bind sup_reset_gen sup_reset_gen_chk #(
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .supply_ok_i(supply_ok_i),
  .mr_n_sync  (mr_n_sync),
  .rst_o      (rst_o),
  .rst_n_o    (rst_n_o)
);

// File: tb/tb_sup_reset_gen.sv
module tb_sup_reset_gen;

  localparam int unsigned T  = 40;
  localparam int unsigned SS = 2;

  logic clk = 1'b0;
  logic rst;
  logic supply_ok_i;
  logic man_rst_n_i;
  logic rst_n_o;
  logic rst_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  sup_reset_gen #(
    .TIMEOUT_CYCLES(T),
    .SYNC_STAGES   (SS)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .supply_ok_i(supply_ok_i),
    .man_rst_n_i(man_rst_n_i),
    .rst_n_o    (rst_n_o),
    .rst_o      (rst_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // counts negedges until reset releases; polarity checked every sample (R7)
  task automatic measure_release(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      check(rst_n_o == !rst_o, "R7", rst_n_o, !rst_o);
    end while (rst_o && n < 4 * T);
  endtask

  task automatic test_por();
    int n;
    rst = 1'b1; supply_ok_i = 1'b0; man_rst_n_i = 1'b1;
    repeat (5) @(negedge clk);
    check(rst_o == 1'b1 && rst_n_o == 1'b0, "R8", rst_o, 1);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    check(rst_o == 1'b1, "R8", rst_o, 1);
    supply_ok_i = 1'b1;
    measure_release(n);
    check(n == T, "R3", n, T);
  endtask

  task automatic test_idle();
    int bad = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (rst_o || !rst_n_o) bad++;
    end
    check(bad == 0, "R9", bad, 0);
    check(rst_n_o == 1'b1 && rst_o == 1'b0, "R7", rst_n_o, 1);
  endtask

  task automatic test_supply_glitch();
    int n;
    supply_ok_i = 1'b0;
    @(negedge clk);
    check(rst_o == 1'b1 && rst_n_o == 1'b0, "R1", rst_o, 1);
    supply_ok_i = 1'b1;
    measure_release(n);
    check(n == T, "R5", n, T);
  endtask

  task automatic test_manual();
    int n;
    man_rst_n_i = 1'b0;
    repeat (SS) @(negedge clk);
    check(rst_o == 1'b0, "R2", rst_o, 0);
    @(negedge clk);
    check(rst_o == 1'b1 && rst_n_o == 1'b0, "R2", rst_o, 1);
    repeat (20) @(negedge clk);
    man_rst_n_i = 1'b1;
    measure_release(n);
    check(n == T + SS, "R4", n, T + SS);
  endtask

  task automatic test_manual_short();
    int n;
    man_rst_n_i = 1'b0;
    @(negedge clk);
    man_rst_n_i = 1'b1;
    repeat (SS) @(negedge clk);
    check(rst_o == 1'b1, "R5", rst_o, 1);
    measure_release(n);
    check(n == T, "R5", n, T);
  endtask

  task automatic test_restart();
    int n;
    int drops = 0;
    supply_ok_i = 1'b0;
    repeat (10) @(negedge clk);
    supply_ok_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!rst_o) drops++;
    end
    supply_ok_i = 1'b0;
    @(negedge clk);
    supply_ok_i = 1'b1;
    measure_release(n);
    check(drops == 0, "R6", drops, 0);
    check(n == T, "R6", n, T);
    // manual pulse in the middle of a supply-triggered countdown
    supply_ok_i = 1'b0;
    @(negedge clk);
    supply_ok_i = 1'b1;
    repeat (15) @(negedge clk);
    man_rst_n_i = 1'b0;
    @(negedge clk);
    man_rst_n_i = 1'b1;
    measure_release(n);
    check(n == T + SS, "R6", n, T + SS);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    test_por();
    test_idle();
    test_supply_glitch();
    test_idle();
    test_manual();
    test_manual_short();
    test_restart();
    test_idle();
    finish_run();
  end

endmodule